// File: doc/BRIEF.md
# Byte-Wide Request/Acknowledge Parallel Port

This controller sits on the device side of an 8-bit parallel link that is paced by two active-low wires. The external peer pulls a request line low to ask for one byte. The controller answers by pulling an acknowledge line low, and it does so only once it can supply or absorb that byte. The width of the acknowledge pulse sets when the byte is valid, how long it is held, and when the data pins are released. A configuration input puts the port in one of two directions. In output mode, bytes come from an internal valid/ready source. In input mode, bytes go to an internal valid/ready sink.

All nanosecond constraints are modelled as cycle counts, which software or strap logic programs. The acknowledge low time, the output data hold time and the output release delay each have their own count. A value of zero counts as one cycle. The request line passes through a two-stage synchronizer, and only a synchronized high-to-low transition can start a transfer. When the internal side has no byte (output mode) or no free buffer (input mode), the acknowledge is held back for as long as necessary.

Top module: `pp_port`

## Requirements
- R1: After reset, ack_n is 1, pd_oe is 0, pd_out is 0, tx_ready is 0, rx_valid is 0 and proto_err is 0.
- R2: A transfer begins only on a synchronized falling edge of req_n. When data or buffer space is already available, ack_n goes low on the 4th rising clock edge after req_n is first sampled low (two synchronizer stages, one start decision, one acceptance).
- R3: In output mode (dir_in = 0), the byte is accepted through tx_valid/tx_ready on the same edge that lowers ack_n. pd_out carries that byte and pd_oe is 1 for the whole time ack_n is low.
- R4: Once low, ack_n stays low for exactly max(ack_cyc, 1) cycles and then returns high.
- R5: In output mode, pd_out keeps the transferred byte for exactly max(hold_cyc, 1) cycles, counted from the cycle in which ack_n returns high. After that, pd_out reads 0.
- R6: In output mode, pd_oe stays 1 for exactly max(hold_cyc, rel_cyc, 1) cycles after ack_n returns high and then drops to 0. Whenever pd_oe is 0, pd_out is 0.
- R7: In input mode (dir_in = 1), pd_in is sampled in the last cycle in which ack_n is low. rx_valid rises together with ack_n and presents that byte on rx_data. Both stay unchanged until rx_ready is seen high.
- R8: With no tx_valid (output mode), or with an unread byte still pending on rx_valid (input mode), ack_n stays high for an unbounded time after a request. It falls once data or space appears.
- R9: If req_n is kept low after a transfer, no further transfer starts. req_n must be seen high again before another falling edge can start one.
- R10: If the synchronized request is high during any cycle in which ack_n is low, proto_err is set and stays set until reset. The acknowledge pulse still lasts its full programmed length.
- R11: The direction is captured when a request is accepted. A change of dir_in while a transfer is pending or running has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_in | input | 1 | Direction select: 1 = input mode, 0 = output mode |
| ack_cyc | input | CW | Acknowledge low time in cycles (0 counts as 1) |
| hold_cyc | input | CW | Output data hold after acknowledge rises, in cycles |
| rel_cyc | input | CW | Output enable release delay after acknowledge rises, in cycles |
| req_n | input | 1 | Asynchronous active-low request from the peer |
| ack_n | output | 1 | Active-low acknowledge to the peer |
| pd_out | output | DW | Data driven onto the port in output mode |
| pd_oe | output | 1 | Output enable for the data pins |
| pd_in | input | DW | Data read from the port in input mode |
| tx_data | input | DW | Byte from the internal source |
| tx_valid | input | 1 | Internal source has a byte |
| tx_ready | output | 1 | Port accepts a byte this cycle |
| rx_data | output | DW | Received byte for the internal sink |
| rx_valid | output | 1 | Received byte is pending |
| rx_ready | input | 1 | Internal sink takes the pending byte |
| proto_err | output | 1 | Sticky flag: request released while acknowledge was low |

## Verification
The hardest states to reach are the stalled ones, where a request is pending but acknowledge must not move. Input mode only stalls after an earlier byte has been left unread on rx_valid. Output mode only stalls while the source is empty. The stimulus creates each stall on purpose and holds it for twenty cycles. It flips dir_in while the port is stalled, then supplies data or drains the buffer. After that it measures the latency of the acknowledge, its low time and the release of the data pins. A second hard case comes from a peer that breaks the protocol. It keeps request low across a whole transfer, or it releases request in the first acknowledge cycle, so that the arming and sticky-error paths are exercised.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // waiting for an armed request fall
    ST_WAIT = 2'd1,  // request seen, waiting for data or buffer space
    ST_ACK  = 2'd2,  // acknowledge low
    ST_POST = 2'd3   // output hold / release tail
  } pp_state_t;
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {STAGES{RST_VAL}};
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pp_timer.sv
module pp_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] limit,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (start)         cnt <= '0;
    else if (cnt != '1)     cnt <= cnt + 1'b1;
  end

  // cycle index (1-based) has reached the limit; a zero limit acts as one
  assign last = ({1'b0, cnt} + (W+1)'(1)) >= {1'b0, limit};
endmodule

// File: rtl/pp_port.sv
module pp_port
  import pp_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir_in,
  input  logic [CW-1:0] ack_cyc,
  input  logic [CW-1:0] hold_cyc,
  input  logic [CW-1:0] rel_cyc,
  input  logic          req_n,
  output logic          ack_n,
  output logic [DW-1:0] pd_out,
  output logic          pd_oe,
  input  logic [DW-1:0] pd_in,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic          proto_err
);
  pp_state_t     state, state_n;
  logic          req_s;
  logic          mode_in;
  logic          armed;
  logic          tmr_start;
  logic          take_tx;
  logic          main_last;
  logic          hold_last;
  logic [CW-1:0] post_lim;
  logic [CW-1:0] main_lim;

  pp_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(req_n), .q(req_s)
  );

  assign post_lim = (hold_cyc > rel_cyc) ? hold_cyc : rel_cyc;
  assign main_lim = (state == ST_ACK) ? ack_cyc : post_lim;

  pp_timer #(.W(CW)) u_main (
    .clk(clk), .rst(rst), .start(tmr_start), .limit(main_lim), .last(main_last)
  );

  pp_timer #(.W(CW)) u_hold (
    .clk(clk), .rst(rst), .start(tmr_start), .limit(hold_cyc), .last(hold_last)
  );

  assign tx_ready = (state == ST_WAIT) && !mode_in;
  assign take_tx  = tx_ready && tx_valid;

  always_comb begin
    state_n   = state;
    tmr_start = 1'b0;
    case (state)
      ST_IDLE: if (armed && !req_s) state_n = ST_WAIT;
      ST_WAIT: begin
        if (mode_in ? !rx_valid : tx_valid) begin
          state_n   = ST_ACK;
          tmr_start = 1'b1;
        end
      end
      ST_ACK: begin
        if (main_last) begin
          tmr_start = 1'b1;
          state_n   = mode_in ? ST_IDLE : ST_POST;
        end
      end
      ST_POST: if (main_last) state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mode_in   <= 1'b0;
      armed     <= 1'b0;
      ack_n     <= 1'b1;
      pd_out    <= '0;
      pd_oe     <= 1'b0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      state <= state_n;

      if (state == ST_IDLE) mode_in <= dir_in;

      if (state == ST_IDLE && state_n == ST_WAIT) armed <= 1'b0;
      else if (req_s)                               armed <= 1'b1;

      if (rx_valid && rx_ready) rx_valid <= 1'b0;

      if (state == ST_WAIT && state_n == ST_ACK) begin
        ack_n <= 1'b0;
        if (take_tx) begin
          pd_out <= tx_data;
          pd_oe  <= 1'b1;
        end
      end

      if (state == ST_ACK) begin
        if (req_s) proto_err <= 1'b1;
        if (main_last) begin
          ack_n <= 1'b1;
          if (mode_in) begin
            rx_data  <= pd_in;
            rx_valid <= 1'b1;
          end
        end
      end

      if (state == ST_POST) begin
        if (hold_last) pd_out <= '0;
        if (main_last) begin
          pd_oe  <= 1'b0;
          pd_out <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/pp_port_chk.sv
module pp_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ack_n,
  input logic          pd_oe,
  input logic [DW-1:0] pd_out,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [DW-1:0] rx_data,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          proto_err,
  input logic          mode_in
);
  // R3: in output mode the byte is taken on the edge that lowers acknowledge
  p_take_on_ack_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(ack_n) && !mode_in) |-> ($past(tx_valid && tx_ready) && pd_oe));

  // R3: data pins stay driven and steady while acknowledge is low
  p_oe_during_ack_r3: assert property (@(posedge clk) disable iff (rst)
    (!ack_n && !$fell(ack_n) && !mode_in) |-> (pd_oe && $stable(pd_out)));

  // R6: undriven pins read zero
  p_zero_when_off_r6: assert property (@(posedge clk) disable iff (rst)
    !pd_oe |-> (pd_out == '0));

  // R7: a pending received byte waits for the sink unchanged
  p_rx_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R8: input mode never acknowledges over an unread byte
  p_no_overwrite_r8: assert property (@(posedge clk) disable iff (rst)
    ($fell(ack_n) && mode_in) |-> !rx_valid);

  // R10: error flag is sticky
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);
endmodule

bind pp_port pp_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .ack_n(ack_n), .pd_oe(pd_oe), .pd_out(pd_out),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .proto_err(proto_err),
  .mode_in(mode_in)
);

// File: tb/pp_port_test.sv
module pp_port_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dir_in = 1'b0;
  logic [7:0] ack_cyc = 8'd1, hold_cyc = 8'd1, rel_cyc = 8'd1;
  logic       req_n = 1'b1;
  logic       ack_n;
  logic [7:0] pd_out;
  logic       pd_oe;
  logic [7:0] pd_in = 8'h00;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic       proto_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pp_port #(.DW(8), .CW(8)) uut (
    .clk(clk), .rst(rst), .dir_in(dir_in), .ack_cyc(ack_cyc),
    .hold_cyc(hold_cyc), .rel_cyc(rel_cyc), .req_n(req_n), .ack_n(ack_n),
    .pd_out(pd_out), .pd_oe(pd_oe), .pd_in(pd_in), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int at_least1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // wait for ack_n to reach a level; returns cycles waited
  task automatic wait_ack(input logic lvl, output int n);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      n++;
      if (ack_n == lvl) break;
    end
  endtask

  // count consecutive low acknowledge cycles, starting on a low one
  task automatic count_low(output int low);
    low = 1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (ack_n == 1'b0) low++;
      else break;
    end
  endtask

  task automatic t_reset;
    chk(ack_n == 1'b1 && pd_oe == 1'b0 && pd_out == 8'h00, "R1 port", {ack_n, pd_oe, pd_out}, 10'h200);
    chk(tx_ready == 1'b0 && rx_valid == 1'b0 && proto_err == 1'b0, "R1 flags",
        {tx_ready, rx_valid, proto_err}, 0);
  endtask

  task automatic xfer_out(input logic [7:0] b, input int al, input int h, input int t);
    int lat, low, ohi, dok, mx;
    ack_cyc = 8'(al); hold_cyc = 8'(h); rel_cyc = 8'(t);
    dir_in = 1'b0; tx_data = b; tx_valid = 1'b1;
    req_n = 1'b0;
    wait_ack(1'b0, lat);
    chk(lat == 4, "R2 latency out", lat, 4);
    chk(pd_out == b && pd_oe == 1'b1, "R3 byte on ack", pd_out, b);
    tx_valid = 1'b0;
    count_low(low);
    chk(low == at_least1(al), "R4 ack low out", low, at_least1(al));
    ohi = 0; dok = 0;
    for (int i = 0; i < 300; i++) begin
      if (!pd_oe) break;
      ohi++;
      if (pd_out == b) dok++;
      @(negedge clk);
    end
    mx = (h > t) ? h : t;
    chk(dok == at_least1(h), "R5 data hold", dok, at_least1(h));
    chk(ohi == at_least1(mx), "R6 release", ohi, at_least1(mx));
    chk(pd_out == 8'h00, "R6 zero after release", pd_out, 0);
    req_n = 1'b1;
    idle(4);
  endtask

  task automatic xfer_in(input logic [7:0] b, input int al, input bit consume);
    int lat, low;
    ack_cyc = 8'(al);
    dir_in = 1'b1; pd_in = b;
    req_n = 1'b0;
    wait_ack(1'b0, lat);
    chk(lat == 4, "R2 latency in", lat, 4);
    chk(pd_oe == 1'b0, "R7 no drive in input mode", pd_oe, 0);
    count_low(low);
    pd_in = ~b;
    chk(low == at_least1(al), "R4 ack low in", low, at_least1(al));
    chk(rx_valid == 1'b1 && rx_data == b, "R7 rx byte", rx_data, b);
    idle(5);
    chk(rx_valid == 1'b1 && rx_data == b, "R7 rx held", rx_data, b);
    if (consume) begin
      rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
      chk(rx_valid == 1'b0, "R7 rx consumed", rx_valid, 0);
    end
    req_n = 1'b1;
    idle(4);
  endtask

  task automatic t_in_stall;
    int n, seen;
    xfer_in(8'h42, 2, 1'b0);
    pd_in = 8'h99;
    req_n = 1'b0;
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!ack_n) seen++;
    end
    chk(seen == 0, "R8 input stall", seen, 0);
    chk(rx_data == 8'h42, "R8 pending byte kept", rx_data, 8'h42);
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
    wait_ack(1'b0, n);
    chk(n <= 3 && ack_n == 1'b0, "R8 input resumes", n, 3);
    wait_ack(1'b1, n);
    chk(rx_valid && rx_data == 8'h99, "R8 new byte", rx_data, 8'h99);
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
    req_n = 1'b1;
    idle(4);
  endtask

  task automatic t_out_stall;
    int seen, n;
    ack_cyc = 8'd2; hold_cyc = 8'd1; rel_cyc = 8'd1;
    dir_in = 1'b0; tx_valid = 1'b0;
    req_n = 1'b0;
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!ack_n) seen++;
    end
    chk(seen == 0, "R8 output stall", seen, 0);
    chk(tx_ready == 1'b1, "R8 ready while stalled", tx_ready, 1);
    dir_in = 1'b1;  // R11: must not affect the pending transfer
    idle(3);
    chk(ack_n == 1'b1 && tx_ready == 1'b1, "R11 dir change ignored", {ack_n, tx_ready}, 3);
    tx_data = 8'h6E; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(ack_n == 1'b0 && pd_out == 8'h6E && pd_oe, "R8 output resumes", pd_out, 8'h6E);
    wait_ack(1'b1, n);
    for (int i = 0; i < 20; i++) begin
      if (!pd_oe) break;
      @(negedge clk);
    end
    chk(rx_valid == 1'b0, "R11 no rx in output transfer", rx_valid, 0);
    dir_in = 1'b0;
    req_n = 1'b1;
    idle(4);
  endtask

  task automatic t_held_req;
    int n, seen;
    ack_cyc = 8'd2; hold_cyc = 8'd1; rel_cyc = 8'd1;
    dir_in = 1'b0; tx_data = 8'h11; tx_valid = 1'b1;
    req_n = 1'b0;
    wait_ack(1'b0, n);
    wait_ack(1'b1, n);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!ack_n) seen++;
    end
    chk(seen == 0, "R9 held request no retrigger", seen, 0);
    tx_valid = 1'b0;
    req_n = 1'b1;
    idle(4);
    xfer_out(8'h22, 1, 1, 1);  // R9: rearmed after high
  endtask

  task automatic t_early_release;
    int n, low;
    chk(proto_err == 1'b0, "R10 clean before", proto_err, 0);
    ack_cyc = 8'd8; hold_cyc = 8'd1; rel_cyc = 8'd1;
    dir_in = 1'b0; tx_data = 8'h77; tx_valid = 1'b1;
    req_n = 1'b0;
    wait_ack(1'b0, n);
    tx_valid = 1'b0;
    req_n = 1'b1;
    count_low(low);
    chk(low == 8, "R10 full pulse", low, 8);
    chk(proto_err == 1'b1, "R10 error set", proto_err, 1);
    idle(6);
    xfer_out(8'h5B, 2, 1, 1);
    chk(proto_err == 1'b1, "R10 error sticky", proto_err, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    idle(3);
    t_reset();
    xfer_out(8'hA5, 3, 2, 4);
    xfer_out(8'h3C, 1, 1, 1);
    xfer_out(8'h81, 0, 0, 0);
    xfer_out(8'h5A, 6, 5, 2);
    xfer_in(8'hC3, 2, 1'b1);
    xfer_in(8'h17, 5, 1'b1);
    t_in_stall();
    t_out_stall();
    t_held_req();
    t_early_release();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule